// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block keeps two registers with one bit per interrupt cause: a pending register, which records requests, and an enable register, which selects the requests software accepts. A third mask comes from three privilege-level enable inputs. Each input opens the software, timer and external cause bits of its own level. A cause can be taken only when its pending, enable and level-mask bits are all set. The block then reports that an interrupt is present and which cause to take. When several causes qualify, the lowest bit index wins.

Surrounding logic sets or clears a single pending bit by cause number, or empties the whole pending register in one cycle. It can also overwrite either register as a full word. Both registers are read back zero-extended to 64 bits. The request and cause outputs are combinational from the registered state and the three level enables. They therefore follow a change of a level enable in the same cycle.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, the pending and enable readbacks are zero and no interrupt is reported.
- R2: A full-word write to pending or enable stores data bits 11:0. The readback returns them in bits 11:0, with bits 63:12 reading as zero.
- R3: A post request with cause number n below 12 sets pending bit n and leaves every other bit unchanged. A cause number of 12 or more has no effect.
- R4: A clear request with cause number n clears pending bit n only. If a post and a clear name the same bit in one cycle, the bit ends up set.
- R5: A clear-all request zeroes the whole pending register, overriding any post or clear in the same cycle.
- R6: A full-word pending write overrides clear-all, post and clear in the same cycle.
- R7: A cause is takeable only when its pending, enable and level-mask bits are all 1. The machine-level enable unmasks bits 3 (software), 7 (timer) and 11 (external).
- R8: The supervisor-level enable unmasks bits 1, 5 and 9.
- R9: The user-level enable unmasks bits 0, 4 and 8. Bits 2, 6 and 10 are never takeable.
- R10: The request output is the OR of all takeable causes. When several are takeable, the cause output gives the lowest bit index.
- R11: When nothing is takeable, the cause output is 0 and its valid flag is low. The request and cause outputs follow the level enables in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Set one pending bit |
| post_idx | input | 4 | Cause number to set |
| clr_vld | input | 1 | Clear one pending bit |
| clr_idx | input | 4 | Cause number to clear |
| clr_all | input | 1 | Zero the whole pending register |
| ip_wr | input | 1 | Full-word write of pending |
| ip_wdata | input | 64 | Pending write data |
| ie_wr | input | 1 | Full-word write of enable |
| ie_wdata | input | 64 | Enable write data |
| lvl_m_en | input | 1 | Machine-level global enable |
| lvl_s_en | input | 1 | Supervisor-level global enable |
| lvl_u_en | input | 1 | User-level global enable |
| ip_rdata | output | 64 | Pending readback, zero-extended |
| ie_rdata | output | 64 | Enable readback, zero-extended |
| irq_req | output | 1 | Some cause is takeable |
| irq_cause | output | 4 | Lowest takeable cause index |
| irq_cause_vld | output | 1 | irq_cause is meaningful |

## Verification
A wrong pending or enable bit shows on the readback ports one cycle after the operation that caused it. It can also show on the request and cause outputs in that same cycle, whenever the level mask lets the bit through. A wrong level-mask or priority decode shows with no delay: it gives a request with a reserved cause, a cause whose pending or enable bit is clear, or a higher index where a lower one qualifies. The random mix drives out-of-range cause numbers and colliding operations, and every cycle is compared against a bench model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Level group of a cause bit: index modulo 4 selects the privilege level.
  localparam int unsigned LVL_USER = 0;
  localparam int unsigned LVL_SUPV = 1;
  localparam int unsigned LVL_RSVD = 2;
  localparam int unsigned LVL_MACH = 3;
  localparam int unsigned LVL_SPAN = 4;
  // Cause kinds occupy consecutive groups of LVL_SPAN bits.
  localparam int unsigned KIND_SOFT  = 0;
  localparam int unsigned KIND_TIMER = 1;
  localparam int unsigned KIND_EXT   = 2;
  localparam int unsigned KIND_COUNT = 3;

  function automatic int unsigned lvl_of(input int unsigned bit_idx);
    return bit_idx % LVL_SPAN;
  endfunction
endpackage

// File: rtl/irq_level_mask.sv
module irq_level_mask #(
  parameter int unsigned NCAUSE = 12
) (
  input  logic              m_en,
  input  logic              s_en,
  input  logic              u_en,
  output logic [NCAUSE-1:0] gmask
);
  import irq_pkg::*;
  localparam int unsigned ARCH_BITS = LVL_SPAN * KIND_COUNT;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
    if (i >= ARCH_BITS) begin : g_none
      assign gmask[i] = 1'b0;
    end else if (lvl_of(i) == LVL_MACH) begin : g_m
      assign gmask[i] = m_en;
    end else if (lvl_of(i) == LVL_SUPV) begin : g_s
      assign gmask[i] = s_en;
    end else if (lvl_of(i) == LVL_USER) begin : g_u
      assign gmask[i] = u_en;
    end else begin : g_rsvd
      assign gmask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NCAUSE = 12,
  parameter int unsigned IW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_vld,
  input  logic [IW-1:0]     post_idx,
  input  logic              clr_vld,
  input  logic [IW-1:0]     clr_idx,
  input  logic              clr_all,
  input  logic              wr,
  input  logic [NCAUSE-1:0] wdata,
  output logic [NCAUSE-1:0] pend
);
  localparam logic [IW:0] LIMIT = (IW+1)'(NCAUSE);

  logic [NCAUSE-1:0] set_m, clr_m;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_dec
    assign set_m[i] = post_vld && ({1'b0, post_idx} < LIMIT) && (post_idx == IW'(i));
    assign clr_m[i] = clr_vld  && ({1'b0, clr_idx}  < LIMIT) && (clr_idx  == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else if (wr) begin
      pend <= wdata;
    end else if (clr_all) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~clr_m) | set_m;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 12,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int unsigned NCAUSE = 12,
  parameter int unsigned DW     = 64,
  localparam int unsigned IW    = (NCAUSE > 1) ? $clog2(NCAUSE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post_vld,
  input  logic [IW-1:0] post_idx,
  input  logic          clr_vld,
  input  logic [IW-1:0] clr_idx,
  input  logic          clr_all,
  input  logic          ip_wr,
  input  logic [DW-1:0] ip_wdata,
  input  logic          ie_wr,
  input  logic [DW-1:0] ie_wdata,
  input  logic          lvl_m_en,
  input  logic          lvl_s_en,
  input  logic          lvl_u_en,
  output logic [DW-1:0] ip_rdata,
  output logic [DW-1:0] ie_rdata,
  output logic          irq_req,
  output logic [IW-1:0] irq_cause,
  output logic          irq_cause_vld
);
  logic [NCAUSE-1:0] pend, enab, gmask, takeable;
  logic              unused_hi;

  assign unused_hi = ^{ip_wdata[DW-1:NCAUSE], ie_wdata[DW-1:NCAUSE]};

  irq_pend_reg #(.NCAUSE(NCAUSE), .IW(IW)) u_pend (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx),
    .clr_all(clr_all),
    .wr(ip_wr), .wdata(ip_wdata[NCAUSE-1:0]),
    .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst)        enab <= '0;
    else if (ie_wr) enab <= ie_wdata[NCAUSE-1:0];
  end

  irq_level_mask #(.NCAUSE(NCAUSE)) u_mask (
    .m_en(lvl_m_en), .s_en(lvl_s_en), .u_en(lvl_u_en), .gmask(gmask)
  );

  assign takeable = pend & enab & gmask;
  assign irq_req  = |takeable;

  irq_prio_enc #(.N(NCAUSE), .IW(IW)) u_enc (
    .req(takeable), .idx(irq_cause), .found(irq_cause_vld)
  );

  assign ip_rdata = {{(DW-NCAUSE){1'b0}}, pend};
  assign ie_rdata = {{(DW-NCAUSE){1'b0}}, enab};
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int unsigned NCAUSE = 12,
  parameter int unsigned DW     = 64,
  parameter int unsigned IW     = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          post_vld,
  input logic [IW-1:0] post_idx,
  input logic          clr_vld,
  input logic          clr_all,
  input logic          ip_wr,
  input logic [DW-1:0] ip_wdata,
  input logic          lvl_m_en,
  input logic          lvl_s_en,
  input logic          lvl_u_en,
  input logic [DW-1:0] ip_rdata,
  input logic [DW-1:0] ie_rdata,
  input logic          irq_req,
  input logic [IW-1:0] irq_cause,
  input logic          irq_cause_vld
);
  AST_REQ_MATCH_VLD: assert property (@(posedge clk) disable iff (rst)
    irq_req == irq_cause_vld); // R10
  AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_cause_vld |-> irq_cause == '0); // R11
  AST_CAUSE_TAKEABLE: assert property (@(posedge clk) disable iff (rst)
    irq_cause_vld |-> (ip_rdata[irq_cause] && ie_rdata[irq_cause])); // R7
  AST_CAUSE_LEVEL_OPEN: assert property (@(posedge clk) disable iff (rst)
    irq_cause_vld |-> ((irq_cause[1:0] == 2'd3 && lvl_m_en) ||
                       (irq_cause[1:0] == 2'd1 && lvl_s_en) ||
                       (irq_cause[1:0] == 2'd0 && lvl_u_en))); // R9
  AST_POST_SETS: assert property (@(posedge clk) disable iff (rst)
    (post_vld && !clr_vld && !clr_all && !ip_wr && post_idx < IW'(NCAUSE))
      |=> ip_rdata[$past(post_idx)]); // R3
  AST_CLRALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !ip_wr) |=> ip_rdata == '0); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    ip_wr |=> ip_rdata == {{(DW-NCAUSE){1'b0}}, $past(ip_wdata[NCAUSE-1:0])}); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ip_rdata[DW-1:NCAUSE] == '0 && ie_rdata[DW-1:NCAUSE] == '0); // R2
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NCAUSE(NCAUSE), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
  .clr_vld(clr_vld), .clr_all(clr_all), .ip_wr(ip_wr), .ip_wdata(ip_wdata),
  .lvl_m_en(lvl_m_en), .lvl_s_en(lvl_s_en), .lvl_u_en(lvl_u_en),
  .ip_rdata(ip_rdata), .ie_rdata(ie_rdata), .irq_req(irq_req),
  .irq_cause(irq_cause), .irq_cause_vld(irq_cause_vld)
);

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic clk = 0, rst = 1;
  logic post_vld = 0, clr_vld = 0, clr_all = 0, ip_wr = 0, ie_wr = 0;
  logic [3:0] post_idx = 0, clr_idx = 0;
  logic [63:0] ip_wdata = 0, ie_wdata = 0;
  logic m_en = 0, s_en = 0, u_en = 0;
  logic [63:0] ip_rdata, ie_rdata;
  logic irq_req, irq_cause_vld;
  logic [3:0] irq_cause;

  int total = 0, bad = 0;
  logic [N-1:0] mp = 0, me = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_ctrl dut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_idx(clr_idx), .clr_all(clr_all),
    .ip_wr(ip_wr), .ip_wdata(ip_wdata), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .lvl_m_en(m_en), .lvl_s_en(s_en), .lvl_u_en(u_en),
    .ip_rdata(ip_rdata), .ie_rdata(ie_rdata), .irq_req(irq_req),
    .irq_cause(irq_cause), .irq_cause_vld(irq_cause_vld)
  );

  function automatic logic [N-1:0] gm(input logic m, input logic s, input logic u);
    logic [N-1:0] g = '0;
    g[3] = m; g[7] = m; g[11] = m;
    g[1] = s; g[5] = s; g[9]  = s;
    g[0] = u; g[4] = u; g[8]  = u;
    return g;
  endfunction

  function automatic logic [4:0] exp_cause(input logic [N-1:0] t);
    for (int i = 0; i < N; i++) if (t[i]) return {1'b1, 4'(i)};
    return 5'd0;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    logic [N-1:0] t;
    logic [4:0] ec;
    logic [63:0] act, exp;
    t  = mp & me & gm(m_en, s_en, u_en);
    ec = exp_cause(t);
    act = {ip_rdata[31:0], ie_rdata[23:0], irq_req, irq_cause_vld, irq_cause, 2'b0};
    exp = {20'd0, mp, 12'd0, me, |t, ec[4], ec[3:0], 2'b0};
    chk(ip_rdata == {52'd0, mp} && ie_rdata == {52'd0, me} && irq_req == |t &&
        irq_cause_vld == ec[4] && irq_cause == ec[3:0], req, act, exp);
  endtask

  // Apply held inputs for one edge, update model, drop pulses.
  task automatic tick();
    logic [N-1:0] sm = '0, cm = '0;
    if (post_vld && post_idx < N) sm[post_idx] = 1'b1;
    if (clr_vld && clr_idx < N) cm[clr_idx] = 1'b1;
    @(posedge clk);
    if (ip_wr) mp = ip_wdata[N-1:0];
    else if (clr_all) mp = '0;
    else mp = (mp & ~cm) | sm;
    if (ie_wr) me = ie_wdata[N-1:0];
    #1;
    post_vld = 0; clr_vld = 0; clr_all = 0; ip_wr = 0; ie_wr = 0;
  endtask

  task automatic wr_ip(input logic [63:0] v);
    @(negedge clk); ip_wr = 1; ip_wdata = v; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk(ip_rdata == 0 && ie_rdata == 0 && !irq_req, "R1", ip_rdata | ie_rdata, 0);

    // R2: all-ones enable write, upper bits dropped
    @(negedge clk); ie_wr = 1; ie_wdata = '1; tick();
    chk(ie_rdata == 64'hFFF, "R2", ie_rdata, 64'hFFF);
    wr_ip(64'hABCD_0000_0000_0A5A);
    chk(ip_rdata == 64'hA5A, "R2", ip_rdata, 64'hA5A);

    // R7: machine bits masked then opened combinationally
    wr_ip(64'h888);
    chk(!irq_req, "R7", {63'd0, irq_req}, 0);
    @(negedge clk); m_en = 1; #1;
    chk(irq_req && irq_cause == 3, "R11", {59'd0, irq_req, irq_cause}, 64'h13);
    chk_all("R7");
    @(negedge clk); m_en = 0; #1;
    chk(!irq_req && !irq_cause_vld && irq_cause == 0, "R11",
        {59'd0, irq_req, irq_cause}, 0);

    // R8 / R9
    @(negedge clk); s_en = 1; wr_ip(64'h222);
    chk(irq_cause_vld && irq_cause == 1, "R8", {60'd0, irq_cause}, 1);
    @(negedge clk); s_en = 0; u_en = 1; wr_ip(64'h110);
    chk(irq_cause_vld && irq_cause == 4, "R9", {60'd0, irq_cause}, 4);
    @(negedge clk); m_en = 1; s_en = 1; wr_ip(64'h444);
    chk(!irq_req, "R9", {63'd0, irq_req}, 0);

    // R3 post
    wr_ip(0);
    @(negedge clk); post_vld = 1; post_idx = 7; tick();
    chk(ip_rdata == 64'h80, "R3", ip_rdata, 64'h80);
    @(negedge clk); post_vld = 1; post_idx = 13; tick();
    chk(ip_rdata == 64'h80, "R3", ip_rdata, 64'h80);

    // R4 clear, collision
    @(negedge clk); clr_vld = 1; clr_idx = 7; post_vld = 1; post_idx = 5; tick();
    chk(ip_rdata == 64'h20, "R4", ip_rdata, 64'h20);
    @(negedge clk); clr_vld = 1; clr_idx = 5; post_vld = 1; post_idx = 5; tick();
    chk(ip_rdata == 64'h20, "R4", ip_rdata, 64'h20);

    // R5 clear-all beats post
    @(negedge clk); clr_all = 1; post_vld = 1; post_idx = 3; tick();
    chk(ip_rdata == 0, "R5", ip_rdata, 0);

    // R6 full write beats everything
    @(negedge clk); ip_wr = 1; ip_wdata = 64'h0F0; clr_all = 1;
    post_vld = 1; post_idx = 0; clr_vld = 1; clr_idx = 4; tick();
    chk(ip_rdata == 64'h0F0, "R6", ip_rdata, 64'h0F0);

    // R10 lowest index wins
    wr_ip(64'hFFF);
    chk(irq_cause == 0 && irq_req, "R10", {60'd0, irq_cause}, 0);
    @(negedge clk); ie_wr = 1; ie_wdata = 64'hFFE; tick();
    chk(irq_cause == 1, "R10", {60'd0, irq_cause}, 1);
    @(negedge clk); s_en = 0; #1;
    chk(irq_cause == 3, "R10", {60'd0, irq_cause}, 3);

    // Random mix against the model (R3 R4 R5 R6 R7 R10 R11)
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      post_vld = ($urandom % 2) == 0;
      post_idx = 4'($urandom);
      clr_vld  = ($urandom % 3) == 0;
      clr_idx  = 4'($urandom);
      clr_all  = ($urandom % 16) == 0;
      ip_wr    = ($urandom % 8) == 0;
      ip_wdata = {$urandom, $urandom};
      ie_wr    = ($urandom % 6) == 0;
      ie_wdata = {$urandom, $urandom};
      m_en = 1'($urandom); s_en = 1'($urandom); u_en = 1'($urandom);
      tick();
      chk_all("R10 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule